// File: doc/BRIEF.md
# Byte-serial TFT sync timing generator

This block produces the horizontal sync, vertical sync and data-valid timing for a 320 by 240 TFT panel. The panel is fed over an 8-bit bus, so each pixel takes several bus clocks: two clocks for 16-bit colour and three for 24-bit colour. Every horizontal quantity is counted in bus clocks and scaled by the parameter `CPP`, the clocks per pixel. The start of the active window is moved later by a fixed pipeline correction that depends on the colour mode.

A free-running horizontal counter advances once per bus clock. A vertical counter advances at the end of each line. A registered decode stage turns the two counters into the active-low syncs, a line-active enable and a byte-phase index. The phase index tells downstream packing logic which colour byte of the current pixel belongs on the bus. The decode stage also publishes the two counters. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the first frame starts a fixed number of clocks after release.

Top module: `tft_sync_gen`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it rises, the outputs are `hs_n`=1, `vs_n`=1, `de`=0, `byte_phase`=0, `h_cnt`=0 and `v_cnt`=0. The third rising edge after release presents frame clock 0.
- R2: `h_cnt` counts bus clocks from 0 to 336*CPP-1 and then returns to 0. `v_cnt` holds its value except at that wrap, where it advances by one.
- R3: `hs_n` is 0 exactly when `h_cnt` < 2*CPP, on every line.
- R4: `vs_n` is 0 exactly when `v_cnt` < VS_LINES (default 2, allowed range 1 to 5). Its falling edge comes in the same clock as the falling edge of `hs_n` at frame clock 0.
- R5: `de` is 1 exactly when `v_cnt` is in 2..241 and `h_cnt` is in S..S+320*CPP-1. Here S = 7*CPP + C, with C = 3 when CPP=2 and C = 5 when CPP=3.
- R6: A frame is 244 lines. After `v_cnt`=243 wraps at the end of its line, the next line has `v_cnt`=0.
- R7: While `de`=1, `byte_phase` is (h_cnt - S) mod CPP, so it starts at 0 on the first active clock of each line. While `de`=0 it is 0.
- R8: If `rst_n` is driven low in the middle of a frame, the outputs take the R1 values without waiting for a clock edge. After release the timing restarts from frame clock 0, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Line-active data window |
| byte_phase | output | P_W | Byte index within the current pixel |
| h_cnt | output | H_W | Bus clock position within the line |
| v_cnt | output | V_W | Line position within the frame |

## Verification
The only input besides the clock is the reset. The assertions are disabled while the internal, synchronised reset is active. They assume that after release the counters advance every clock with no gaps. The stimulus changes `rst_n` a quarter period after a rising edge, so its release never lands on an edge. It releases reset once at start-up and once in the middle of a line. Two instances run side by side, one with CPP=2 and one with CPP=3. The CPP=2 instance runs through a full frame and wraps into the next one; the CPP=3 instance covers well over half a frame.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;
  localparam int ACT_PIX     = 320;
  localparam int TOT_PIX     = 336;
  localparam int HS_PIX      = 2;
  localparam int LEAD_PIX    = 7;
  localparam int ACT_LINES   = 240;
  localparam int BLANK_LINES = 4;

  function automatic int pipe_corr(input int cpp);
    return (cpp == 3) ? 5 : 3;
  endfunction
endpackage

// File: rtl/tft_sync_rst.sv
module tft_sync_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/tft_sync_hcount.sv
module tft_sync_hcount #(
  parameter int H_PERIOD = 672,
  parameter int H_W      = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [H_W-1:0] h_q,
  output logic           line_end
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_PERIOD - 1);

  logic [H_W-1:0] h_d;

  always_comb begin
    line_end = (h_q == H_LAST);
    h_d      = line_end ? '0 : h_q + H_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= '0;
    else        h_q <= h_d;
  end

  AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= H_LAST); // R2
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_q == '0)); // R2
endmodule

// File: rtl/tft_sync_vcount.sv
module tft_sync_vcount #(
  parameter int V_LINES = 244,
  parameter int V_W     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  output logic [V_W-1:0] v_q
);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_LINES - 1);

  logic [V_W-1:0] v_d;

  always_comb begin
    v_d = (v_q == V_LAST) ? '0 : v_q + V_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   v_q <= '0;
    else if (adv) v_q <= v_d;
  end

  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_q == V_LAST) |=> (v_q == '0)); // R6
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(v_q)); // R2
endmodule

// File: rtl/tft_sync_decode.sv
module tft_sync_decode #(
  parameter int CPP      = 2,
  parameter int H_W      = 10,
  parameter int V_W      = 8,
  parameter int P_W      = 1,
  parameter int HS_W     = 4,
  parameter int H_START  = 17,
  parameter int H_ACT    = 640,
  parameter int V_FIRST  = 2,
  parameter int V_ACT    = 240,
  parameter int VS_LINES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] h_i,
  input  logic [V_W-1:0] v_i,
  output logic           hs_n_q,
  output logic           vs_n_q,
  output logic           de_q,
  output logic [P_W-1:0] phase_q,
  output logic [H_W-1:0] h_q,
  output logic [V_W-1:0] v_q
);
  localparam logic [H_W-1:0] HS_END    = H_W'(HS_W);
  localparam logic [H_W-1:0] WIN_BEGIN = H_W'(H_START);
  localparam logic [H_W-1:0] WIN_END   = H_W'(H_START + H_ACT);
  localparam logic [V_W-1:0] VS_END    = V_W'(VS_LINES);
  localparam logic [V_W-1:0] ROW_BEGIN = V_W'(V_FIRST);
  localparam logic [V_W-1:0] ROW_END   = V_W'(V_FIRST + V_ACT);
  localparam logic [P_W-1:0] PH_LAST   = P_W'(CPP - 1);

  logic           hs_n_d, vs_n_d, de_d, row_act;
  logic [P_W-1:0] phase_d;

  always_comb begin
    hs_n_d  = !(h_i < HS_END);
    vs_n_d  = !(v_i < VS_END);
    row_act = (v_i >= ROW_BEGIN) && (v_i < ROW_END);
    de_d    = row_act && (h_i >= WIN_BEGIN) && (h_i < WIN_END);
    if (!de_d || !de_q || phase_q == PH_LAST) phase_d = '0;
    else                                      phase_d = phase_q + P_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_n_q  <= 1'b1;
      vs_n_q  <= 1'b1;
      de_q    <= 1'b0;
      phase_q <= '0;
      h_q     <= '0;
      v_q     <= '0;
    end else begin
      hs_n_q  <= hs_n_d;
      vs_n_q  <= vs_n_d;
      de_q    <= de_d;
      phase_q <= phase_d;
      h_q     <= h_i;
      v_q     <= v_i;
    end
  end

  AST_DE_OUTSIDE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> hs_n_q); // R5
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST); // R7
  AST_PHASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_q) |-> (phase_q == '0)); // R7
  AST_HS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_n_q) |=> !hs_n_q); // R3
  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_n_q) |-> $fell(hs_n_q)); // R4
endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
#(
  parameter int CPP      = 2,
  parameter int VS_LINES = 2,
  parameter int H_W      = $clog2(TOT_PIX * CPP),
  parameter int V_W      = $clog2(ACT_LINES + BLANK_LINES),
  parameter int P_W      = (CPP > 1) ? $clog2(CPP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           hs_n,
  output logic           vs_n,
  output logic           de,
  output logic [P_W-1:0] byte_phase,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt
);
  localparam int H_PERIOD = TOT_PIX * CPP;
  localparam int HS_W     = HS_PIX * CPP;
  localparam int H_START  = LEAD_PIX * CPP + pipe_corr(CPP);
  localparam int H_ACT    = ACT_PIX * CPP;
  localparam int V_LINES  = ACT_LINES + BLANK_LINES;
  localparam int V_FIRST  = BLANK_LINES / 2;

  logic           rst_i_n;
  logic [H_W-1:0] h_raw;
  logic [V_W-1:0] v_raw;
  logic           line_end;

  tft_sync_rst u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tft_sync_hcount #(.H_PERIOD(H_PERIOD), .H_W(H_W)) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .h_q      (h_raw),
    .line_end (line_end)
  );

  tft_sync_vcount #(.V_LINES(V_LINES), .V_W(V_W)) u_vcnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .adv   (line_end),
    .v_q   (v_raw)
  );

  tft_sync_decode #(
    .CPP(CPP), .H_W(H_W), .V_W(V_W), .P_W(P_W), .HS_W(HS_W),
    .H_START(H_START), .H_ACT(H_ACT), .V_FIRST(V_FIRST),
    .V_ACT(ACT_LINES), .VS_LINES(VS_LINES)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .h_i     (h_raw),
    .v_i     (v_raw),
    .hs_n_q  (hs_n),
    .vs_n_q  (vs_n),
    .de_q    (de),
    .phase_q (byte_phase),
    .h_q     (h_cnt),
    .v_q     (v_cnt)
  );
endmodule

// File: tb/tft_sync_gen_tb.sv
module tft_sync_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n;
  int   tests = 0;
  int   fails = 0;
  int   rel   = 0;
  int   cycles = 0;
  bit   mid_phase = 1'b0;
  bit   done = 1'b0;

  logic       hs2_n, vs2_n, de2;
  logic [0:0] ph2;
  logic [9:0] h2;
  logic [7:0] v2;
  logic       hs3_n, vs3_n, de3;
  logic [1:0] ph3;
  logic [9:0] h3;
  logic [7:0] v3;

  always #(CLK_PERIOD/2) clk = ~clk;

  tft_sync_gen #(.CPP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_n(hs2_n), .vs_n(vs2_n), .de(de2),
    .byte_phase(ph2), .h_cnt(h2), .v_cnt(v2));

  tft_sync_gen #(.CPP(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .hs_n(hs3_n), .vs_n(vs3_n), .de(de3),
    .byte_phase(ph3), .h_cnt(h3), .v_cnt(v3));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) rel <= 0;
    else        rel <= rel + 1;
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_one(input int cpp, input int hs, input int vs, input int de,
                           input int ph, input int h, input int v);
    int e_hs, e_vs, e_de, e_ph, e_h, e_v, t, hp, st;
    string rtag;
    hp = 336 * cpp;
    st = 7 * cpp + ((cpp == 3) ? 5 : 3);
    rtag = mid_phase ? "R8" : "R1";
    if (!rst_n || rel < 3) begin
      cmp(rtag, "hs_n", hs, 1); cmp(rtag, "vs_n", vs, 1); cmp(rtag, "de", de, 0);
      cmp(rtag, "byte_phase", ph, 0); cmp(rtag, "h_cnt", h, 0); cmp(rtag, "v_cnt", v, 0);
    end else begin
      t    = rel - 3;
      e_h  = t % hp;
      e_v  = (t / hp) % 244;
      e_hs = (e_h < 2 * cpp) ? 0 : 1;
      e_vs = (e_v < 2) ? 0 : 1;
      e_de = (e_v >= 2 && e_v <= 241 && e_h >= st && e_h < st + 320 * cpp) ? 1 : 0;
      e_ph = e_de ? (e_h - st) % cpp : 0;
      cmp("R2", "h_cnt", h, e_h);
      cmp("R6", "v_cnt", v, e_v);
      cmp("R3", "hs_n", hs, e_hs);
      cmp("R4", "vs_n", vs, e_vs);
      cmp("R5", "de", de, e_de);
      cmp("R7", "byte_phase", ph, e_ph);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n !== 1'bx && !done) begin
      check_one(2, hs2_n, vs2_n, de2, int'(ph2), int'(h2), int'(v2));
      check_one(3, hs3_n, vs3_n, de3, int'(ph3), int'(h3), int'(v3));
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    rst_n = 1'b0;
    wait_cycles(5);
    rst_n = 1'b1;           // R1: release, frame starts on third edge
    wait_cycles(2000);
    mid_phase = 1'b1;
    rst_n = 1'b0;           // R8: mid-line reset
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(164500);    // R6: full CPP=2 frame plus wrap
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule